// File: doc/BRIEF.md
# Extended-Precision Add/Subtract Flag ALU

This combinational unit does one step of a multi-word add, subtract or negate, the kind an integer core performs when it chains operations on numbers wider than its registers. The carry or borrow from the previous step comes in on the extend input and is folded into the arithmetic. The unit returns the sized result together with a new set of condition flags: extend, negative, zero, overflow and carry.

Operands can be a byte, a word or a long, and every output is formed at that size. The zero flag is sticky across a chain. A nonzero step clears it, and a zero step passes the incoming value through unchanged. Software sets zero before the first step, and after the last step the flag shows whether the whole multi-word value is zero. Negate is a subtraction from zero and has a simpler overflow term.

Top module: `xflag_alu`

## Requirements
- R1: With opSel = 2'b00 (add), result equals (dst + src + xIn) modulo 2^w, where w is the selected width.
- R2: With opSel = 2'b01 (subtract), result equals (dst − src − xIn) modulo 2^w.
- R3: With opSel = 2'b10 (negate), result equals (0 − src − xIn) modulo 2^w, and dst has no effect on any output.
- R4: xOut and cOut both equal the carry out of bit w−1 for add, or the borrow out of bit w−1 for subtract and negate.
- R5: zOut is 0 when the sized result is nonzero and equals zIn when the sized result is zero.
- R6: nOut equals bit w−1 of the result.
- R7: For add, vOut is bit w−1 of (res XOR src) AND NOT (dst XOR src).
- R8: For subtract, vOut is bit w−1 of (res XOR dst) AND (dst XOR src).
- R9: For negate, vOut is bit w−1 of (res AND src).
- R10: Result bits at or above w are 0, and operand bits at or above w have no effect on any output.
- R11: sizeSel selects the width: 2'b00 gives byte (w=8), 2'b01 gives word (w=16), 2'b10 and 2'b11 give long (w=32). opSel = 2'b11 behaves as add.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| srcIn | input | 32 | Source operand |
| dstIn | input | 32 | Destination operand (ignored for negate) |
| opSel | input | 2 | Operation: 00 add, 01 subtract, 10 negate, 11 add |
| sizeSel | input | 2 | Width: 00 byte, 01 word, 1x long |
| xIn | input | 1 | Incoming extend bit (carry or borrow in) |
| zIn | input | 1 | Incoming zero flag |
| result | output | 32 | Sized result, zero-extended |
| xOut | output | 1 | New extend flag |
| nOut | output | 1 | New negative flag |
| zOut | output | 1 | New sticky zero flag |
| vOut | output | 1 | New overflow flag |
| cOut | output | 1 | New carry flag |

## Verification
The bench steers operands toward the edges of every width: all-ones plus an incoming extend, zero minus an incoming extend, and the most negative value under negate. A carry taken from a fixed bit 32 would stay silent at byte and word size. A design that used the general subtract overflow term for negate would report overflow on the wrong results. The bench also applies a zero result with zIn low, which catches a zero flag that sets instead of holding. It fills operand bits above the selected width with noise, which exposes any leak of upper bits into the result or the flags.

// File: rtl/xflag_pkg.sv
package xflag_pkg;
  localparam int BASE_W = 8;
  localparam int LANES  = 3;
  localparam int TOP_W  = BASE_W << (LANES - 1);

  typedef enum logic [1:0] {
    OP_ADD     = 2'b00,
    OP_SUB     = 2'b01,
    OP_NEG     = 2'b10,
    OP_ADD_ALT = 2'b11
  } opKind_t;

  typedef enum logic [1:0] {
    SZ_BYTE     = 2'b00,
    SZ_WORD     = 2'b01,
    SZ_LONG     = 2'b10,
    SZ_LONG_ALT = 2'b11
  } sizeKind_t;

  typedef struct packed {
    logic             subtract;
    logic             dropDest;
    logic [LANES-1:0] laneSel;
  } aluStrobe_t;
endpackage

// File: rtl/xflag_ctrl.sv
module xflag_ctrl
  import xflag_pkg::*;
(
  input  logic [1:0] opSel,
  input  logic [1:0] sizeSel,
  output aluStrobe_t strb
);
  opKind_t   opKind;
  sizeKind_t sizeKind;

  assign opKind   = opKind_t'(opSel);
  assign sizeKind = sizeKind_t'(sizeSel);

  always_comb begin
    strb = '0;
    unique case (opKind)
      OP_SUB:  begin strb.subtract = 1'b1; strb.dropDest = 1'b0; end
      OP_NEG:  begin strb.subtract = 1'b1; strb.dropDest = 1'b1; end
      default: begin strb.subtract = 1'b0; strb.dropDest = 1'b0; end
    endcase
    unique case (sizeKind)
      SZ_BYTE: strb.laneSel = LANES'(1);
      SZ_WORD: strb.laneSel = LANES'(2);
      default: strb.laneSel = LANES'(1) << (LANES - 1);
    endcase
  end

  // exactly one lane chosen for every legal size code (R11)
  always_comb begin
    if (!$isunknown(sizeSel))
      assert_lane_onehot_R11: assert ($countones(strb.laneSel) == 1);
  end

  // negate never runs as an add (R3)
  always_comb begin
    if (!$isunknown(opSel))
      assert_neg_is_sub_R3: assert (!strb.dropDest || strb.subtract);
  end
endmodule

// File: rtl/xflag_datapath.sv
module xflag_datapath
  import xflag_pkg::*;
#(
  parameter int LANE_BASE = BASE_W,
  parameter int LANE_CNT  = LANES,
  localparam int WIDE     = LANE_BASE << (LANE_CNT - 1)
) (
  input  logic [WIDE-1:0]  srcVal,
  input  logic [WIDE-1:0]  dstVal,
  input  aluStrobe_t       strb,
  input  logic             xIn,
  input  logic             zIn,
  output logic [WIDE-1:0]  result,
  output logic             xOut,
  output logic             nOut,
  output logic             zOut,
  output logic             vOut,
  output logic             cOut
);
  logic [WIDE-1:0] laneRes   [LANE_CNT];
  logic            laneCarry [LANE_CNT];
  logic            laneOv    [LANE_CNT];
  logic            laneMsb   [LANE_CNT];

  for (genvar k = 0; k < LANE_CNT; k++) begin : g_lane
    localparam int W = LANE_BASE << k;
    logic [W-1:0] opA, opB, sumR;
    logic [W:0]   ext;
    logic         ovf;

    always_comb begin
      opA = strb.dropDest ? '0 : dstVal[W-1:0];
      opB = srcVal[W-1:0];
      if (strb.subtract)
        ext = {1'b0, opA} - {1'b0, opB} - {{W{1'b0}}, xIn};
      else
        ext = {1'b0, opA} + {1'b0, opB} + {{W{1'b0}}, xIn};
      sumR = ext[W-1:0];
      if (!strb.subtract)
        ovf = (sumR[W-1] ^ opB[W-1]) & ~(opA[W-1] ^ opB[W-1]);
      else if (strb.dropDest)
        ovf = sumR[W-1] & opB[W-1];
      else
        ovf = (sumR[W-1] ^ opA[W-1]) & (opA[W-1] ^ opB[W-1]);
    end

    assign laneRes[k]   = WIDE'(sumR);
    assign laneCarry[k] = ext[W];
    assign laneOv[k]    = ovf;
    assign laneMsb[k]   = sumR[W-1];
  end

  logic carrySel;

  always_comb begin
    result   = '0;
    carrySel = 1'b0;
    vOut     = 1'b0;
    nOut     = 1'b0;
    for (int k = 0; k < LANE_CNT; k++) begin
      if (strb.laneSel[k]) begin
        result   = result | laneRes[k];
        carrySel = carrySel | laneCarry[k];
        vOut     = vOut | laneOv[k];
        nOut     = nOut | laneMsb[k];
      end
    end
  end

  assign xOut = carrySel;
  assign cOut = carrySel;
  assign zOut = zIn & (result == '0);

  logic inputsKnown;
  assign inputsKnown = !$isunknown({srcVal, dstVal, strb, xIn, zIn});

  // zero may only be cleared, never set (R5)
  always_comb begin
    if (inputsKnown)
      assert_z_sticky_R5: assert (!zOut || zIn);
  end

  // byte lane leaves the upper result bits clear (R10)
  always_comb begin
    if (inputsKnown && strb.laneSel[0])
      assert_upper_clear_R10: assert (result[WIDE-1:LANE_BASE] == '0);
  end

  // negate overflows only into a negative result (R9)
  always_comb begin
    if (inputsKnown && strb.dropDest && vOut)
      assert_neg_ovf_sign_R9: assert (nOut);
  end

  // a negative result always clears zero (R5, R6)
  always_comb begin
    if (inputsKnown && nOut)
      assert_neg_not_zero_R6: assert (!zOut);
  end

  // add overflow needs a result sign unlike the source sign (R7)
  always_comb begin
    if (inputsKnown && !strb.subtract && vOut && strb.laneSel[LANE_CNT-1])
      assert_add_ovf_R7: assert (nOut != srcVal[WIDE-1]);
  end
endmodule

// File: rtl/xflag_alu.sv
module xflag_alu
  import xflag_pkg::*;
(
  input  logic [31:0] srcIn,
  input  logic [31:0] dstIn,
  input  logic [1:0]  opSel,
  input  logic [1:0]  sizeSel,
  input  logic        xIn,
  input  logic        zIn,
  output logic [31:0] result,
  output logic        xOut,
  output logic        nOut,
  output logic        zOut,
  output logic        vOut,
  output logic        cOut
);
  aluStrobe_t strb;

  xflag_ctrl i_ctrl (
    .opSel   (opSel),
    .sizeSel (sizeSel),
    .strb    (strb)
  );

  xflag_datapath #(
    .LANE_BASE (BASE_W),
    .LANE_CNT  (LANES)
  ) i_dp (
    .srcVal (srcIn),
    .dstVal (dstIn),
    .strb   (strb),
    .xIn    (xIn),
    .zIn    (zIn),
    .result (result),
    .xOut   (xOut),
    .nOut   (nOut),
    .zOut   (zOut),
    .vOut   (vOut),
    .cOut   (cOut)
  );

  // extend and carry always agree (R4)
  always_comb begin
    if (!$isunknown({srcIn, dstIn, opSel, sizeSel, xIn}))
      assert_xc_match_R4: assert (xOut == cOut);
  end
endmodule

// File: tb/test_xflag_alu.sv
module test_xflag_alu;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] srcIn = '0, dstIn = '0;
  logic [1:0]  opSel = '0, sizeSel = '0;
  logic        xIn = 1'b0, zIn = 1'b0;
  logic [31:0] result;
  logic        xOut, nOut, zOut, vOut, cOut;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  xflag_alu i_xflag_alu (
    .srcIn(srcIn), .dstIn(dstIn), .opSel(opSel), .sizeSel(sizeSel),
    .xIn(xIn), .zIn(zIn), .result(result), .xOut(xOut), .nOut(nOut),
    .zOut(zOut), .vOut(vOut), .cOut(cOut)
  );

  // behavioural reference built on wide signed integers
  function automatic void refModel(
    input longint s, input longint d, input int op, input int sz,
    input int x, input int z,
    output longint res, output int cx, output int n, output int zo, output int v);
    int w;
    longint mask, t, sm, dm;
    w = (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
    mask = (longint'(1) << w) - 1;
    sm = s & mask;
    dm = (op == 2) ? 0 : (d & mask);
    if (op == 1 || op == 2) begin
      t  = dm - sm - x;
      cx = (t < 0) ? 1 : 0;
    end else begin
      t  = dm + sm + x;
      cx = int'((t >> w) & 1);
    end
    res = t & mask;
    n   = int'((res >> (w - 1)) & 1);
    zo  = (z != 0 && res == 0) ? 1 : 0;
    if (op == 2)      v = int'(((res & sm) >> (w - 1)) & 1);
    else if (op == 1) v = int'((((res ^ dm) & (dm ^ sm)) >> (w - 1)) & 1);
    else              v = int'((((res ^ sm) & ~(dm ^ sm)) >> (w - 1)) & 1);
  endfunction

  function automatic string tagFor(input int op);
    return (op == 1) ? "R2/R8" : (op == 2) ? "R3/R9" : "R1/R7";
  endfunction

  task automatic applyVec(input logic [31:0] s, input logic [31:0] d,
                          input int op, input int sz, input int x, input int z,
                          input string note);
    longint eRes;
    int eC, eN, eZ, eV;
    @(posedge clk);
    srcIn = s; dstIn = d; opSel = op[1:0]; sizeSel = sz[1:0];
    xIn = x[0]; zIn = z[0];
    @(negedge clk);
    refModel(longint'(s), longint'(d), op, sz, x, z, eRes, eC, eN, eZ, eV);
    vectors++;
    if (result != eRes[31:0]) begin
      miscompares++;
      $display("FAIL %s R10 R11 result %s: got %h exp %h", tagFor(op), note, result, eRes[31:0]);
    end
    if (xOut != eC[0] || cOut != eC[0]) begin
      miscompares++;
      $display("FAIL R4 carry %s: got x=%0b c=%0b exp %0d", note, xOut, cOut, eC);
    end
    if (nOut != eN[0]) begin
      miscompares++;
      $display("FAIL R6 nOut %s: got %0b exp %0d", note, nOut, eN);
    end
    if (zOut != eZ[0]) begin
      miscompares++;
      $display("FAIL R5 zOut %s: got %0b exp %0d", note, zOut, eZ);
    end
    if (vOut != eV[0]) begin
      miscompares++;
      $display("FAIL %s vOut %s: got %0b exp %0d", tagFor(op), note, vOut, eV);
    end
  endtask

  initial begin : watchdog
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        miscompares++;
        $display("FAIL watchdog expired after %0d cycles", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
      end
    end
  end

  function automatic logic [31:0] pickOperand(input int sz);
    int sel;
    logic [31:0] top, noise;
    top = (sz == 0) ? 32'h80 : (sz == 1) ? 32'h8000 : 32'h8000_0000;
    noise = $urandom;
    sel = $urandom_range(0, 7);
    case (sel)
      0: return (noise & ~((top << 1) - 1)) | 32'h0;
      1: return (noise & ~((top << 1) - 1)) | ((top << 1) - 1);
      2: return (noise & ~((top << 1) - 1)) | top;
      3: return (noise & ~((top << 1) - 1)) | (top - 1);
      4: return (noise & ~((top << 1) - 1)) | 32'h1;
      default: return noise;
    endcase
  endfunction

  initial begin : stim
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    // reset state: all-zero inputs, add byte, zero held
    applyVec(32'h0, 32'h0, 0, 0, 0, 1, "R1 idle zero");
    // R1 carry at each width
    applyVec(32'h0000_00FF, 32'h0000_0000, 0, 0, 1, 1, "R1 R4 byte wrap");
    applyVec(32'h0000_FFFF, 32'h0000_0000, 0, 1, 1, 1, "R1 R4 word wrap");
    applyVec(32'hFFFF_FFFF, 32'h0000_0000, 0, 2, 1, 1, "R1 R4 long wrap");
    applyVec(32'h7FFF_FFFF, 32'h0000_0001, 0, 2, 0, 0, "R7 long ovf");
    // R2 borrow
    applyVec(32'h0000_0000, 32'h0000_0000, 1, 0, 1, 1, "R2 R4 byte borrow");
    applyVec(32'h0000_0001, 32'h0000_8000, 1, 1, 0, 0, "R8 word ovf");
    applyVec(32'h0000_0005, 32'h0000_0005, 1, 2, 0, 0, "R5 zero keeps clear");
    applyVec(32'h0000_0005, 32'h0000_0005, 1, 2, 0, 1, "R5 zero keeps set");
    // R3 negate ignores dst; most negative overflows
    applyVec(32'h0000_0080, 32'hDEAD_BEEF, 2, 0, 0, 1, "R3 R9 byte min");
    applyVec(32'h8000_0000, 32'h1234_5678, 2, 2, 0, 1, "R3 R9 long min");
    applyVec(32'h0000_0000, 32'hFFFF_FFFF, 2, 1, 0, 1, "R3 neg zero");
    applyVec(32'h0000_0000, 32'hFFFF_FFFF, 2, 1, 1, 1, "R3 R4 neg zero x");
    // R10 upper noise; R11 alternate codes
    applyVec(32'hABCD_EF01, 32'h1234_56FF, 0, 0, 0, 1, "R10 byte noise");
    applyVec(32'h1234_5678, 32'h9ABC_DEF0, 3, 3, 1, 1, "R11 alt codes");
    // sweep all ops, sizes and flag inputs
    for (int i = 0; i < 6000; i++) begin
      int op = $urandom_range(0, 3);
      int sz = $urandom_range(0, 3);
      applyVec(pickOperand(sz), pickOperand(sz), op, sz,
               $urandom_range(0, 1), $urandom_range(0, 1), "sweep");
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule